// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches page translations in a small fully associative array. Every slot carries a virtual page tag, a physical page number, an address-space identifier, a global flag that makes the slot visible to every address space, per-privilege-mode read and write permission masks, and two trap flags, one for reads and one for writes. A combinational probe port takes a virtual page and the current address-space identifier. In the same cycle it returns whether a usable slot exists, which slot it is, and what that slot holds.

New translations enter through an insert channel that uses valid/ready. The slot that is written is always the one named by a rotating victim pointer, and the pointer steps after every accepted insert. The same pointer drives a read-out port that shows the slot it names, and a control pin steps the pointer after such a read. Three invalidation controls are plain pins: drop everything, drop every slot that is not global, and drop the slots that a given page and address space would hit. Ports with the prefixes `probe_`, `fill_`, `inv_` and `vict_` form these four groups.

Back-pressure rule: `fill_ready` is low in any cycle that raises an invalidation control, and it is high otherwise. An insert is taken only on a cycle where `fill_valid` and `fill_ready` are both high. A source holding `fill_valid` keeps its data stable until it sees that handshake.

Top module: `xlat_tlb`

## Requirements
- R1: `probe_hit` is 1 exactly when some slot is valid, its tag equals `probe_vpn`, and either its global flag is set or its stored address-space identifier equals `probe_asn`.
- R2: When several slots qualify, `probe_idx` names the one with the lowest index.
- R3: An accepted insert writes every field of the slot named by the victim pointer, sets that slot's tag to `fill_vpn`, marks it valid, and overwrites any valid contents.
- R4: After reset all slots are invalid and the victim pointer is 0. The pointer steps by one after each accepted insert and wraps from DEPTH-1 to 0.
- R5: Asserting `inv_all` invalidates every slot and returns the victim pointer to 0 at the next clock edge, whatever else is requested in that cycle.
- R6: Asserting `inv_nonglobal` invalidates every slot whose global flag is clear and leaves global slots valid and unchanged.
- R7: Asserting `inv_page` invalidates every valid slot whose tag equals `inv_vpn` and that is either global or holds `inv_asn`. Other slots are kept.
- R8: `fill_ready` is 0 while any invalidation control is high. An insert offered in such a cycle writes nothing and does not move the pointer.
- R9: `vict_idx`, `vict_valid`, `vict_vpn`, `vict_ppn`, `vict_asn` and `vict_global` show the slot at the victim pointer. `vict_step` steps the pointer with wrap. If it coincides with an accepted insert, the pointer steps only once.
- R10: On a hit, `probe_ppn`, `probe_rd_en`, `probe_wr_en`, `probe_trap_rd`, `probe_trap_wr` and `probe_global` carry the hit slot's fields. On a miss all of them are 0 and `probe_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_vpn | input | VPN_W | Virtual page to translate |
| probe_asn | input | ASN_W | Current address-space identifier |
| probe_hit | output | 1 | A qualifying slot exists |
| probe_idx | output | IDX_W | Index of the lowest qualifying slot |
| probe_ppn | output | PPN_W | Physical page of the hit slot |
| probe_global | output | 1 | Global flag of the hit slot |
| probe_rd_en | output | MODES | Read permission per mode |
| probe_wr_en | output | MODES | Write permission per mode |
| probe_trap_rd | output | 1 | Trap-on-read flag |
| probe_trap_wr | output | 1 | Trap-on-write flag |
| fill_valid | input | 1 | Insert offered |
| fill_ready | output | 1 | Insert can be taken this cycle |
| fill_vpn | input | VPN_W | Tag of the new slot |
| fill_ppn | input | PPN_W | Physical page of the new slot |
| fill_asn | input | ASN_W | Address space of the new slot |
| fill_global | input | 1 | Global flag of the new slot |
| fill_rd_en | input | MODES | Read permission mask |
| fill_wr_en | input | MODES | Write permission mask |
| fill_trap_rd | input | 1 | Trap-on-read flag |
| fill_trap_wr | input | 1 | Trap-on-write flag |
| inv_all | input | 1 | Invalidate all slots and reset the pointer |
| inv_nonglobal | input | 1 | Invalidate non-global slots |
| inv_page | input | 1 | Invalidate slots matching inv_vpn/inv_asn |
| inv_vpn | input | VPN_W | Page for inv_page |
| inv_asn | input | ASN_W | Address space for inv_page |
| vict_step | input | 1 | Step the victim pointer |
| vict_idx | output | IDX_W | Victim pointer |
| vict_valid | output | 1 | Valid flag of the victim slot |
| vict_vpn | output | VPN_W | Tag of the victim slot |
| vict_ppn | output | PPN_W | Physical page of the victim slot |
| vict_asn | output | ASN_W | Address space of the victim slot |
| vict_global | output | 1 | Global flag of the victim slot |

## Verification
Probe results and `fill_ready` are combinational, so they are due in the same cycle as their inputs. The bench drives inputs just after a falling edge and compares them a short delay later, before the next rising edge. Inserts, invalidations and pointer moves act at the next rising edge and are visible from then on through the probe and victim ports. The bench's reference model therefore updates right after that edge, and its values are compared in the following cycle. Random operations with colliding pages and address spaces cover the ordering and mixing rules. Directed sequences cover wrap-around, global-versus-private invalidation, and inserts that arrive together with an invalidation.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_STEP = 2'd1,
    PTR_ZERO = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/xlat_tlb_match.sv
module xlat_tlb_match #(
  parameter int DEPTH = 64,
  parameter int VPN_W = 20,
  parameter int ASN_W = 8
) (
  input  logic [DEPTH-1:0] slot_valid,
  input  logic [DEPTH-1:0] slot_global,
  input  logic [VPN_W-1:0] slot_tag [DEPTH],
  input  logic [ASN_W-1:0] slot_asn [DEPTH],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [ASN_W-1:0] key_asn,
  output logic [DEPTH-1:0] match_vec
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic tag_eq;
    logic space_ok;
    assign tag_eq      = (slot_tag[g] == key_vpn);
    assign space_ok    = slot_global[g] | (slot_asn[g] == key_asn);
    assign match_vec[g] = slot_valid[g] & tag_eq & space_ok;
  end
endmodule

// File: rtl/xlat_tlb_first.sv
module xlat_tlb_first #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] req_vec,
  output logic             any,
  output logic [IDX_W-1:0] first_idx
);
  always_comb begin
    any       = 1'b0;
    first_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        any       = 1'b1;
        first_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim
  import xlat_tlb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ptr_op_e          op,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  logic [IDX_W-1:0] ptr_nx;

  always_comb begin
    unique case (op)
      PTR_ZERO: ptr_nx = '0;
      PTR_STEP: ptr_nx = (ptr == LAST) ? '0 : ptr + IDX_W'(1);
      default:  ptr_nx = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nx;
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int ASN_W = 8,
  parameter int MODES = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] probe_vpn,
  input  logic [ASN_W-1:0] probe_asn,
  output logic             probe_hit,
  output logic [IDX_W-1:0] probe_idx,
  output logic [PPN_W-1:0] probe_ppn,
  output logic             probe_global,
  output logic [MODES-1:0] probe_rd_en,
  output logic [MODES-1:0] probe_wr_en,
  output logic             probe_trap_rd,
  output logic             probe_trap_wr,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [ASN_W-1:0] fill_asn,
  input  logic             fill_global,
  input  logic [MODES-1:0] fill_rd_en,
  input  logic [MODES-1:0] fill_wr_en,
  input  logic             fill_trap_rd,
  input  logic             fill_trap_wr,
  input  logic             inv_all,
  input  logic             inv_nonglobal,
  input  logic             inv_page,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [ASN_W-1:0] inv_asn,
  input  logic             vict_step,
  output logic [IDX_W-1:0] vict_idx,
  output logic             vict_valid,
  output logic [VPN_W-1:0] vict_vpn,
  output logic [PPN_W-1:0] vict_ppn,
  output logic [ASN_W-1:0] vict_asn,
  output logic             vict_global
);
  // slot storage
  logic [DEPTH-1:0] val_q;
  logic [DEPTH-1:0] glb_q;
  logic [VPN_W-1:0] tag_q [DEPTH];
  logic [PPN_W-1:0] ppn_q [DEPTH];
  logic [ASN_W-1:0] asn_q [DEPTH];
  logic [MODES-1:0] rde_q [DEPTH];
  logic [MODES-1:0] wre_q [DEPTH];
  logic [DEPTH-1:0] trd_q;
  logic [DEPTH-1:0] twr_q;

  logic [DEPTH-1:0] probe_vec;
  logic [DEPTH-1:0] page_vec;
  logic [DEPTH-1:0] kill_vec;
  logic             any_inv;
  logic             fill_fire;
  logic             first_any;
  logic [IDX_W-1:0] first_idx;
  ptr_op_e          ptr_op;

  // probe path
  xlat_tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_probe_cmp (
    .slot_valid (val_q),
    .slot_global(glb_q),
    .slot_tag   (tag_q),
    .slot_asn   (asn_q),
    .key_vpn    (probe_vpn),
    .key_asn    (probe_asn),
    .match_vec  (probe_vec)
  );

  xlat_tlb_first #(.DEPTH(DEPTH)) u_first (
    .req_vec  (probe_vec),
    .any      (first_any),
    .first_idx(first_idx)
  );

  // page invalidation compare uses the same visibility rule
  xlat_tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_page_cmp (
    .slot_valid (val_q),
    .slot_global(glb_q),
    .slot_tag   (tag_q),
    .slot_asn   (asn_q),
    .key_vpn    (inv_vpn),
    .key_asn    (inv_asn),
    .match_vec  (page_vec)
  );

  assign any_inv    = inv_all | inv_nonglobal | inv_page;
  assign fill_ready = ~any_inv;
  assign fill_fire  = fill_valid & fill_ready;

  always_comb begin
    kill_vec = {DEPTH{inv_all}};
    if (inv_nonglobal) kill_vec = kill_vec | (val_q & ~glb_q);
    if (inv_page)      kill_vec = kill_vec | page_vec;
  end

  always_comb begin
    if (inv_all)                      ptr_op = PTR_ZERO;
    else if (fill_fire || vict_step)  ptr_op = PTR_STEP;
    else                              ptr_op = PTR_HOLD;
  end

  xlat_tlb_victim #(.DEPTH(DEPTH)) u_victim (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (ptr_op),
    .ptr  (vict_idx)
  );

  // per-slot state
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic wr_here;
    assign wr_here = fill_fire && (vict_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[s] <= 1'b0;
        glb_q[s] <= 1'b0;
        tag_q[s] <= '0;
        ppn_q[s] <= '0;
        asn_q[s] <= '0;
        rde_q[s] <= '0;
        wre_q[s] <= '0;
        trd_q[s] <= 1'b0;
        twr_q[s] <= 1'b0;
      end else if (kill_vec[s]) begin
        val_q[s] <= 1'b0;
      end else if (wr_here) begin
        val_q[s] <= 1'b1;
        glb_q[s] <= fill_global;
        tag_q[s] <= fill_vpn;
        ppn_q[s] <= fill_ppn;
        asn_q[s] <= fill_asn;
        rde_q[s] <= fill_rd_en;
        wre_q[s] <= fill_wr_en;
        trd_q[s] <= fill_trap_rd;
        twr_q[s] <= fill_trap_wr;
      end
    end
  end

  // probe outputs, zeroed on a miss
  always_comb begin
    probe_hit     = first_any;
    probe_idx     = first_idx;
    probe_ppn     = '0;
    probe_global  = 1'b0;
    probe_rd_en   = '0;
    probe_wr_en   = '0;
    probe_trap_rd = 1'b0;
    probe_trap_wr = 1'b0;
    if (first_any) begin
      probe_ppn     = ppn_q[first_idx];
      probe_global  = glb_q[first_idx];
      probe_rd_en   = rde_q[first_idx];
      probe_wr_en   = wre_q[first_idx];
      probe_trap_rd = trd_q[first_idx];
      probe_trap_wr = twr_q[first_idx];
    end
  end

  // victim read-out
  assign vict_valid  = val_q[vict_idx];
  assign vict_vpn    = tag_q[vict_idx];
  assign vict_ppn    = ppn_q[vict_idx];
  assign vict_asn    = asn_q[vict_idx];
  assign vict_global = glb_q[vict_idx];
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             probe_hit,
  input logic [IDX_W-1:0] probe_idx,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic             inv_all,
  input logic             inv_nonglobal,
  input logic             inv_page,
  input logic             vict_step,
  input logic [IDX_W-1:0] vict_idx,
  input logic             vict_valid
);
  logic fire;
  assign fire = fill_valid && fill_ready;

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vict_idx) < DEPTH); // R4

  AST_HIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |-> int'(probe_idx) < DEPTH); // R2

  AST_INV_STALLS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all || inv_nonglobal || inv_page) |-> !fill_ready); // R8

  AST_INV_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vict_idx == '0 && !vict_valid && !probe_hit)); // R5

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_all && (fire || vict_step)) |=>
      (int'(vict_idx) == ((int'($past(vict_idx)) == DEPTH - 1) ? 0 : int'($past(vict_idx)) + 1))); // R4

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_all && !fire && !vict_step) |=> $stable(vict_idx)); // R9
endmodule

bind xlat_tlb xlat_tlb_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .probe_hit    (probe_hit),
  .probe_idx    (probe_idx),
  .fill_valid   (fill_valid),
  .fill_ready   (fill_ready),
  .inv_all      (inv_all),
  .inv_nonglobal(inv_nonglobal),
  .inv_page     (inv_page),
  .vict_step    (vict_step),
  .vict_idx     (vict_idx),
  .vict_valid   (vict_valid)
);

// File: tb/xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module xlat_tlb_tb_top;
  localparam int D  = 8;
  localparam int VW = 8;
  localparam int PW = 10;
  localparam int AW = 4;
  localparam int MW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [VW-1:0] probe_vpn = '0;
  logic [AW-1:0] probe_asn = '0;
  logic probe_hit, probe_global, probe_trap_rd, probe_trap_wr;
  logic [IW-1:0] probe_idx;
  logic [PW-1:0] probe_ppn;
  logic [MW-1:0] probe_rd_en, probe_wr_en;
  logic fill_valid = 0, fill_ready, fill_global = 0, fill_trap_rd = 0, fill_trap_wr = 0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic [AW-1:0] fill_asn = '0;
  logic [MW-1:0] fill_rd_en = '0, fill_wr_en = '0;
  logic inv_all = 0, inv_nonglobal = 0, inv_page = 0, vict_step = 0;
  logic [VW-1:0] inv_vpn = '0;
  logic [AW-1:0] inv_asn = '0;
  logic [IW-1:0] vict_idx;
  logic vict_valid, vict_global;
  logic [VW-1:0] vict_vpn;
  logic [PW-1:0] vict_ppn;
  logic [AW-1:0] vict_asn;

  xlat_tlb #(.DEPTH(D), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODES(MW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .probe_vpn(probe_vpn), .probe_asn(probe_asn), .probe_hit(probe_hit),
    .probe_idx(probe_idx), .probe_ppn(probe_ppn), .probe_global(probe_global),
    .probe_rd_en(probe_rd_en), .probe_wr_en(probe_wr_en),
    .probe_trap_rd(probe_trap_rd), .probe_trap_wr(probe_trap_wr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_asn(fill_asn), .fill_global(fill_global),
    .fill_rd_en(fill_rd_en), .fill_wr_en(fill_wr_en),
    .fill_trap_rd(fill_trap_rd), .fill_trap_wr(fill_trap_wr),
    .inv_all(inv_all), .inv_nonglobal(inv_nonglobal), .inv_page(inv_page),
    .inv_vpn(inv_vpn), .inv_asn(inv_asn), .vict_step(vict_step),
    .vict_idx(vict_idx), .vict_valid(vict_valid), .vict_vpn(vict_vpn),
    .vict_ppn(vict_ppn), .vict_asn(vict_asn), .vict_global(vict_global)
  );

  // reference model
  bit        m_v [D];
  bit        m_g [D];
  bit [VW-1:0] m_vpn [D];
  bit [PW-1:0] m_ppn [D];
  bit [AW-1:0] m_asn [D];
  bit [MW-1:0] m_rd [D];
  bit [MW-1:0] m_wr [D];
  bit        m_trd [D];
  bit        m_twr [D];
  int        m_ptr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_find(bit [VW-1:0] v, bit [AW-1:0] a);
    for (int i = 0; i < D; i++)
      if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_asn[i] == a)) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < D; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_asn[i] = 0;
      m_rd[i] = 0; m_wr[i] = 0; m_trd[i] = 0; m_twr[i] = 0;
    end
    m_ptr = 0;
  endtask

  // combinational outputs compared against the pre-edge model
  task automatic check_all();
    int e;
    bit inv;
    #2;
    e = m_find(probe_vpn, probe_asn);
    inv = inv_all | inv_nonglobal | inv_page;
    chk("R1 probe_hit", probe_hit, e >= 0);
    if (e >= 0) begin
      chk("R2 probe_idx", probe_idx, e);
      chk("R10 probe_ppn", probe_ppn, m_ppn[e]);
      chk("R10 probe_global", probe_global, m_g[e]);
      chk("R10 probe_rd_en", probe_rd_en, m_rd[e]);
      chk("R10 probe_wr_en", probe_wr_en, m_wr[e]);
      chk("R10 probe_trap", {probe_trap_rd, probe_trap_wr}, {m_trd[e], m_twr[e]});
    end else begin
      chk("R10 miss idx/ppn", {probe_idx, probe_ppn}, 0);
      chk("R10 miss flags", {probe_global, probe_rd_en, probe_wr_en, probe_trap_rd, probe_trap_wr}, 0);
    end
    chk("R4 vict_idx", vict_idx, m_ptr);
    chk("R9 vict_valid", vict_valid, m_v[m_ptr]);
    if (m_v[m_ptr]) begin
      chk("R9 vict_vpn", vict_vpn, m_vpn[m_ptr]);
      chk("R9 vict_ppn/asn/global", {vict_ppn, vict_asn, vict_global},
          {m_ppn[m_ptr], m_asn[m_ptr], m_g[m_ptr]});
    end
    chk("R8 fill_ready", fill_ready, !inv);
  endtask

  // state update for the rising edge that follows
  task automatic model_edge();
    bit fire;
    bit kill [D];
    fire = fill_valid && !(inv_all || inv_nonglobal || inv_page);
    for (int i = 0; i < D; i++)
      kill[i] = inv_all || (inv_nonglobal && m_v[i] && !m_g[i]) ||
                (inv_page && m_v[i] && m_vpn[i] == inv_vpn && (m_g[i] || m_asn[i] == inv_asn));
    for (int i = 0; i < D; i++) if (kill[i]) m_v[i] = 0;
    if (fire) begin
      m_v[m_ptr] = 1; m_g[m_ptr] = fill_global; m_vpn[m_ptr] = fill_vpn;
      m_ppn[m_ptr] = fill_ppn; m_asn[m_ptr] = fill_asn; m_rd[m_ptr] = fill_rd_en;
      m_wr[m_ptr] = fill_wr_en; m_trd[m_ptr] = fill_trap_rd; m_twr[m_ptr] = fill_trap_wr;
    end
    if (inv_all) m_ptr = 0;
    else if (fire || vict_step) m_ptr = (m_ptr + 1) % D;
  endtask

  // one cycle: inputs already set after a falling edge
  task automatic cycle();
    check_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    fill_valid = 0; inv_all = 0; inv_nonglobal = 0; inv_page = 0; vict_step = 0;
  endtask

  task automatic put(bit [VW-1:0] v, bit [PW-1:0] p, bit [AW-1:0] a, bit g);
    idle();
    fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_asn = a; fill_global = g;
    fill_rd_en = MW'(p); fill_wr_en = MW'(p >> 2); fill_trap_rd = p[0]; fill_trap_wr = p[1];
    cycle();
    idle();
  endtask

  task automatic look(bit [VW-1:0] v, bit [AW-1:0] a);
    probe_vpn = v; probe_asn = a;
    #2;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_71b0);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state, R4
    look(8'h05, 4'h2);
    chk("R4 reset no hit", probe_hit, 0);
    chk("R4 reset pointer", vict_idx, 0);
    chk("R4 reset slot invalid", vict_valid, 0);
    @(negedge clk);

    // R3: insert lands at pointer
    put(8'h05, 10'h033, 4'h2, 0);
    look(8'h05, 4'h2);
    chk("R3 hit after insert", probe_hit, 1);
    chk("R3 slot index", probe_idx, 0);
    chk("R3 ppn", probe_ppn, 10'h033);
    look(8'h05, 4'h3);
    chk("R1 other asn misses", probe_hit, 0);

    // R2: global duplicate at a higher slot, lowest wins
    put(8'h05, 10'h077, 4'h9, 1);
    look(8'h05, 4'h3);
    chk("R1 global visible", probe_hit, 1);
    chk("R2 global slot idx", probe_idx, 1);
    look(8'h05, 4'h2);
    chk("R2 lowest of two", probe_idx, 0);

    // R8: insert with invalidate is dropped
    fill_valid = 1; fill_vpn = 8'h44; fill_ppn = 10'h111; fill_asn = 4'h1; fill_global = 0;
    inv_page = 1; inv_vpn = 8'hEE; inv_asn = 4'h0;
    cycle();
    idle();
    look(8'h44, 4'h1);
    chk("R8 dropped insert", probe_hit, 0);
    chk("R8 pointer unmoved", vict_idx, 2);

    // R7: page invalidate removes private and global slots for vpn 5 asn 2
    inv_page = 1; inv_vpn = 8'h05; inv_asn = 4'h2;
    cycle();
    idle();
    look(8'h05, 4'h9);
    chk("R7 page gone", probe_hit, 0);

    // R6: nonglobal flush keeps globals
    put(8'h10, 10'h010, 4'h1, 0);
    put(8'h11, 10'h011, 4'h1, 1);
    inv_nonglobal = 1;
    cycle();
    idle();
    look(8'h10, 4'h1);
    chk("R6 private removed", probe_hit, 0);
    look(8'h11, 4'h7);
    chk("R6 global kept", probe_hit, 1);

    // R4 wrap + R9 step
    for (int i = 0; i < D; i++) put(8'h20 + VW'(i), 10'h100 + PW'(i), 4'h0, 0);
    chk("R4 wrapped pointer", vict_idx, 4);
    vict_step = 1;
    fill_valid = 1; fill_vpn = 8'h30; fill_ppn = 10'h3;
    cycle();
    idle();
    chk("R9 step with insert once", vict_idx, 5);
    vict_step = 1;
    cycle();
    idle();
    chk("R9 step alone", vict_idx, 6);

    // R5: flush all wins over step
    inv_all = 1; vict_step = 1;
    cycle();
    idle();
    look(8'h21, 4'h0);
    chk("R5 all gone", probe_hit, 0);
    chk("R5 pointer zero", vict_idx, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 63);
      fill_valid = $urandom_range(0, 1);
      fill_vpn = VW'($urandom_range(0, 11));
      fill_ppn = PW'($urandom);
      fill_asn = AW'($urandom_range(0, 3));
      fill_global = ($urandom_range(0, 4) == 0);
      fill_rd_en = MW'($urandom); fill_wr_en = MW'($urandom);
      fill_trap_rd = $urandom_range(0, 1); fill_trap_wr = $urandom_range(0, 1);
      inv_all = (r == 0);
      inv_nonglobal = (r == 1 || r == 2);
      inv_page = (r >= 3 && r < 8);
      inv_vpn = VW'($urandom_range(0, 11));
      inv_asn = AW'($urandom_range(0, 3));
      vict_step = ($urandom_range(0, 7) == 0);
      probe_vpn = VW'($urandom_range(0, 11));
      probe_asn = AW'($urandom_range(0, 3));
      cycle();
    end
    idle();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule